// File: doc/BRIEF.md
# Indexed Extended Register File with Cursor Latch

The block puts a file of 256 byte-wide extended registers behind two byte addresses on a narrow host bus. Offset 0xE holds the register index and offset 0xF is a window onto the register that the index selects. Software writes the index once. Every later access to the data offset then reads or writes that entry. The index stays where it is until software writes it again.

Four of the entries hold the hardware cursor position as low and high bytes of a horizontal and a vertical start. The indices of these four entries are parameters. Writing three of them only stores the byte. A write to the vertical-start high byte starts a latch. The block then copies both 16-bit coordinates to its outputs at the same moment, turns the cursor on and pulses an update strobe. Software can therefore move the cursor with four byte writes, and a display overlay never sees a half-updated position. The overlay also receives a fixed cursor size of 12 by 22 pixels.

A small state machine drives the cursor side. It has three states:
- `CS_DARK`: no latch has happened since reset.
- `CS_LATCH`: a latch is in progress.
- `CS_SHOWN`: the cursor is on and waiting.

It has three transitions:
- `T_ARM`: a vertical-start high write moves the machine from `CS_DARK` or `CS_SHOWN` into `CS_LATCH`.
- `T_RELATCH`: another such write arrives while the machine is in `CS_LATCH`, and it stays there.
- `T_SETTLE`: the machine leaves `CS_LATCH` for `CS_SHOWN` when no such write arrives.

Top module: `xreg_cursor`

## Requirements
- R1: After reset the index is 0x00, all 256 entries read as 0x00, the cursor position is (0,0), the cursor enable is low and the update strobe is low.
- R2: A bus write (sel=1, wr=1) to offset 0xE loads the index. A read (sel=1, wr=0) of offset 0xE returns it. Every read returns its byte on `bus_rdata` with `bus_rvalid` high in the cycle after the read is taken.
- R3: A write to offset 0xF stores the byte in the entry selected by the index. A read of offset 0xF returns that entry.
- R4: The index does not change after a data access: repeated accesses at offset 0xF all hit the same entry, and the next entry keeps its value.
- R5: A write to the horizontal-start low, horizontal-start high or vertical-start low entry (default indices 0x30, 0x31, 0x32) stores the byte. It does not change `cur_x`, `cur_y` or `cur_upd`.
- R6: A write to the vertical-start high entry (default index 0x33) latches two values: `cur_x` = HLO + 256·HHI and `cur_y` = VLO + 256·VHI. The new position appears one clock after the write is taken. `cur_upd` is high for exactly that cycle, and it is not high in any other cycle.
- R7: The first latch sets `cur_en`, and `cur_en` then stays high until reset.
- R8: `cur_w` is always 12 and `cur_h` is always 22.
- R9: An access to any offset other than 0xE or 0xF has no effect: a write changes neither the index nor any entry, and a read returns 0x00.
- R10: All 256 entries are independent storage. Each entry holds its own written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset (0xE index, 0xF data) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, one cycle after the read |
| bus_rvalid | output | 1 | Marks `bus_rdata` valid |
| cur_x | output | 16 | Latched cursor X |
| cur_y | output | 16 | Latched cursor Y |
| cur_en | output | 1 | Cursor enabled |
| cur_upd | output | 1 | One-cycle strobe per position latch |
| cur_w | output | 8 | Cursor width in pixels (12) |
| cur_h | output | 8 | Cursor height in pixels (22) |

## Verification
The bench writes three of the position bytes and then checks that the outputs have not moved. A design that latched on every position byte would show a torn coordinate and an extra strobe at that point. It writes the same entry twice and checks that the neighbouring entry stays zero, which catches an index that auto-increments. It writes at an unused offset and reads it back, which catches decode aliasing, for example onto the data window. It also drives high bytes up to 0xFF and sweeps the whole array. A wrong shift or a truncated index would show up there as wrong coordinates or aliased entries.

// File: rtl/xreg_pkg.sv
package xreg_pkg;
    localparam int unsigned DATA_W   = 8;
    localparam int unsigned ADDR_W   = 4;
    localparam int unsigned SIZE_W   = 8;
    localparam logic [ADDR_W-1:0] OFS_INDEX = 4'hE;
    localparam logic [ADDR_W-1:0] OFS_DATA  = 4'hF;

    typedef enum logic [1:0] {
        CS_DARK  = 2'd0,
        CS_LATCH = 2'd1,
        CS_SHOWN = 2'd2
    } cur_state_e;
endpackage

// File: rtl/xreg_index.sv
module xreg_index #(
    parameter int unsigned IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [IDX_W-1:0] load_val,
    output logic [IDX_W-1:0] idx
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (load) begin
            idx <= load_val;
        end
    end
endmodule

// File: rtl/xreg_array.sv
module xreg_array #(
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned IDX_W   = 8,
    parameter int unsigned HLO_IDX = 8'h30,
    parameter int unsigned HHI_IDX = 8'h31,
    parameter int unsigned VLO_IDX = 8'h32,
    parameter int unsigned VHI_IDX = 8'h33
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  sel_idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] tap_hlo,
    output logic [DATA_W-1:0] tap_hhi,
    output logic [DATA_W-1:0] tap_vlo,
    output logic [DATA_W-1:0] tap_vhi
);
    localparam int unsigned DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] mem [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[e] <= '0;
            end else if (wr_en && (sel_idx == IDX_W'(e))) begin
                mem[e] <= wr_data;
            end
        end
    end

    assign rd_data = mem[sel_idx];
    assign tap_hlo = mem[HLO_IDX];
    assign tap_hhi = mem[HHI_IDX];
    assign tap_vlo = mem[VLO_IDX];
    assign tap_vhi = mem[VHI_IDX];
endmodule

// File: rtl/xreg_cursor_fsm.sv
module xreg_cursor_fsm
    import xreg_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                vhi_wr,
    input  logic [DATA_W-1:0]   hlo,
    input  logic [DATA_W-1:0]   hhi,
    input  logic [DATA_W-1:0]   vlo,
    input  logic [DATA_W-1:0]   vhi,
    output logic [2*DATA_W-1:0] pos_x,
    output logic [2*DATA_W-1:0] pos_y,
    output logic                en,
    output logic                upd
);
    cur_state_e state_q, state_d;

    // next-state logic: T_ARM, T_RELATCH, T_SETTLE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CS_DARK:  if (vhi_wr) state_d = CS_LATCH;
            CS_SHOWN: if (vhi_wr) state_d = CS_LATCH;
            CS_LATCH: state_d = vhi_wr ? CS_LATCH : CS_SHOWN;
            default:  state_d = CS_DARK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CS_DARK;
        end else begin
            state_q <= state_d;
        end
    end

    // output registers: loaded while in CS_LATCH
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_x <= '0;
            pos_y <= '0;
            en    <= 1'b0;
            upd   <= 1'b0;
        end else begin
            upd <= 1'b0;
            unique case (state_q)
                CS_LATCH: begin
                    pos_x <= {hhi, hlo};
                    pos_y <= {vhi, vlo};
                    en    <= 1'b1;
                    upd   <= 1'b1;
                end
                CS_DARK, CS_SHOWN: ;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/xreg_cursor.sv
module xreg_cursor
    import xreg_pkg::*;
#(
    parameter int unsigned IDX_W     = 8,
    parameter int unsigned HLO_IDX   = 8'h30,
    parameter int unsigned HHI_IDX   = 8'h31,
    parameter int unsigned VLO_IDX   = 8'h32,
    parameter int unsigned VHI_IDX   = 8'h33,
    parameter int unsigned CUR_W_PIX = 12,
    parameter int unsigned CUR_H_PIX = 22
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [3:0]          bus_addr,
    input  logic [7:0]          bus_wdata,
    output logic [7:0]          bus_rdata,
    output logic                bus_rvalid,
    output logic [15:0]         cur_x,
    output logic [15:0]         cur_y,
    output logic                cur_en,
    output logic                cur_upd,
    output logic [7:0]          cur_w,
    output logic [7:0]          cur_h
);
    localparam int unsigned POS_W = 2 * DATA_W;

    logic              hit_idx, hit_dat;
    logic              idx_load, dat_wr, rd_req, vhi_wr;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] arr_rd, t_hlo, t_hhi, t_vlo, t_vhi;
    logic [DATA_W-1:0] rd_mux;
    logic [POS_W-1:0]  px, py;

    assign hit_idx  = bus_sel && (bus_addr == OFS_INDEX);
    assign hit_dat  = bus_sel && (bus_addr == OFS_DATA);
    assign idx_load = hit_idx && bus_wr;
    assign dat_wr   = hit_dat && bus_wr;
    assign rd_req   = bus_sel && !bus_wr;
    assign vhi_wr   = dat_wr && (idx_q == IDX_W'(VHI_IDX));

    xreg_index #(.IDX_W(IDX_W)) u_index (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (idx_load),
        .load_val (bus_wdata[IDX_W-1:0]),
        .idx      (idx_q)
    );

    xreg_array #(
        .DATA_W (DATA_W), .IDX_W (IDX_W),
        .HLO_IDX(HLO_IDX), .HHI_IDX(HHI_IDX),
        .VLO_IDX(VLO_IDX), .VHI_IDX(VHI_IDX)
    ) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (dat_wr),
        .sel_idx (idx_q),
        .wr_data (bus_wdata),
        .rd_data (arr_rd),
        .tap_hlo (t_hlo),
        .tap_hhi (t_hhi),
        .tap_vlo (t_vlo),
        .tap_vhi (t_vhi)
    );

    xreg_cursor_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .vhi_wr (vhi_wr),
        .hlo    (t_hlo),
        .hhi    (t_hhi),
        .vlo    (t_vlo),
        .vhi    (t_vhi),
        .pos_x  (px),
        .pos_y  (py),
        .en     (cur_en),
        .upd    (cur_upd)
    );

    always_comb begin
        rd_mux = '0;
        if (bus_addr == OFS_INDEX) begin
            rd_mux = DATA_W'(idx_q);
        end else if (bus_addr == OFS_DATA) begin
            rd_mux = arr_rd;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= rd_req;
            if (rd_req) begin
                bus_rdata <= rd_mux;
            end
        end
    end

    assign cur_x = px;
    assign cur_y = py;
    assign cur_w = SIZE_W'(CUR_W_PIX);
    assign cur_h = SIZE_W'(CUR_H_PIX);
endmodule

// File: rtl/xreg_cursor_chk.sv
module xreg_cursor_chk #(
    parameter int unsigned IDX_W   = 8,
    parameter int unsigned VHI_IDX = 8'h33
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic [3:0]       bus_addr,
    input logic             bus_rvalid,
    input logic [IDX_W-1:0] idx_q,
    input logic [15:0]      cur_x,
    input logic [15:0]      cur_y,
    input logic             cur_en,
    input logic             cur_upd
);
    logic vhi_write;
    assign vhi_write = bus_sel && bus_wr && (bus_addr == 4'hF) && (idx_q == IDX_W'(VHI_IDX));

    p_rvalid_follows_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr) |=> bus_rvalid);
    p_rvalid_only_after_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_wr) |=> !bus_rvalid);
    p_index_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_wr && bus_addr == 4'hE) |=> $stable(idx_q));
    p_pos_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cur_upd |-> ($stable(cur_x) && $stable(cur_y)));
    p_upd_from_vhi_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cur_upd |-> $past(vhi_write, 2));
    p_vhi_leads_upd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        vhi_write |=> ##1 cur_upd);
    p_en_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cur_en |=> cur_en);
    p_en_with_upd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cur_upd |-> cur_en);
endmodule

bind xreg_cursor xreg_cursor_chk #(.IDX_W(IDX_W), .VHI_IDX(VHI_IDX)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_rvalid (bus_rvalid),
    .idx_q      (idx_q),
    .cur_x      (cur_x),
    .cur_y      (cur_y),
    .cur_en     (cur_en),
    .cur_upd    (cur_upd)
);

// File: tb/tb_xreg_cursor.sv
module tb_xreg_cursor;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        bus_rvalid;
    logic [15:0] cur_x, cur_y;
    logic        cur_en, cur_upd;
    logic [7:0]  cur_w, cur_h;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    typedef struct { logic [7:0] val; string req; } exp_t;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    xreg_cursor dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .cur_x(cur_x), .cur_y(cur_y),
        .cur_en(cur_en), .cur_upd(cur_upd), .cur_w(cur_w), .cur_h(cur_h)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        sb.push_back('{val: exp, req: req});
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic set_entry(input logic [7:0] i, input logic [7:0] d);
        bus_write(4'hE, i);
        bus_write(4'hF, d);
    endtask

    // monitor: compares read data against the scoreboard
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (sb.size() == 0) begin
                check("R2 unexpected rvalid", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(e.req, {24'h0, bus_rdata}, {24'h0, e.val});
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 cur_x", cur_x, 0);
        check("R1 cur_y", cur_y, 0);
        check("R1 cur_en", cur_en, 0);
        check("R1 cur_upd", cur_upd, 0);
        bus_read(4'hE, 8'h00, "R1 index");
        bus_read(4'hF, 8'h00, "R1 entry0");
        // R8 fixed size
        check("R8 cur_w", cur_w, 12);
        check("R8 cur_h", cur_h, 22);

        // R2 / R3 index and data
        bus_write(4'hE, 8'h40);
        bus_read(4'hE, 8'h40, "R2 index readback");
        bus_write(4'hF, 8'hAA);
        bus_read(4'hF, 8'hAA, "R3 data readback");
        // R4 no auto-increment
        bus_write(4'hF, 8'hBB);
        bus_read(4'hF, 8'hBB, "R4 same entry rewritten");
        bus_read(4'hE, 8'h40, "R4 index unchanged");
        bus_write(4'hE, 8'h41);
        bus_read(4'hF, 8'h00, "R4 next entry untouched");

        // R9 unused offsets
        bus_write(4'h5, 8'h77);
        bus_write(4'h0, 8'h12);
        bus_read(4'h5, 8'h00, "R9 read unused offset");
        bus_read(4'hE, 8'h41, "R9 index kept");
        bus_read(4'hF, 8'h00, "R9 entry kept");

        // R5 three position bytes store without latching
        set_entry(8'h30, 8'h34);
        set_entry(8'h31, 8'h01);
        set_entry(8'h32, 8'h45);
        repeat (2) @(negedge clk);
        check("R5 x unchanged", cur_x, 0);
        check("R5 y unchanged", cur_y, 0);
        check("R5 no strobe", cur_upd, 0);
        check("R7 still off", cur_en, 0);
        bus_read(4'hF, 8'h45, "R5 byte stored");

        // R6 latch on vertical-start high
        bus_write(4'hE, 8'h33);
        bus_write(4'hF, 8'h02);
        check("R6 no strobe yet", cur_upd, 0);
        @(negedge clk);
        check("R6 strobe", cur_upd, 1);
        check("R6 cur_x", cur_x, 16'h0134);
        check("R6 cur_y", cur_y, 16'h0245);
        check("R7 enabled", cur_en, 1);
        @(negedge clk);
        check("R6 strobe one cycle", cur_upd, 0);

        // R5 then R6 again: low byte alone does not move X
        set_entry(8'h30, 8'hFF);
        repeat (2) @(negedge clk);
        check("R5 x held", cur_x, 16'h0134);
        set_entry(8'h33, 8'h02);
        @(negedge clk);
        check("R6 relatch x", cur_x, 16'h01FF);
        check("R6 relatch y", cur_y, 16'h0245);

        // R6 maximum values
        set_entry(8'h31, 8'hFF);
        set_entry(8'h32, 8'hFF);
        set_entry(8'h33, 8'hFF);
        @(negedge clk);
        check("R6 max x", cur_x, 16'hFFFF);
        check("R6 max y", cur_y, 16'hFFFF);
        @(negedge clk);
        check("R7 sticky", cur_en, 1);

        // R10 sweep all entries
        for (int i = 0; i < 256; i++) set_entry(i[7:0], i[7:0] ^ 8'h5A);
        for (int i = 0; i < 256; i++) begin
            bus_write(4'hE, i[7:0]);
            bus_read(4'hF, i[7:0] ^ 8'h5A, "R10 entry");
        end
        check("R8 cur_w kept", cur_w, 12);

        repeat (3) @(negedge clk);
        check("R2 scoreboard drained", sb.size(), 0);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule